// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel left and right sample words. It watches a bit clock, a frame clock and a serial data line, all sampled in the system clock domain. On every rising bit-clock edge it takes one data bit. A change of the frame clock marks the start of a new channel slot. When a slot ends, the block assembles the slot's bits into a 24-bit word.

A static 3-bit mode input picks the framing. It can select left-justified framing, or framing where the frame clock edge leads the data by one bit. It can also select right-justified framing in one of four word lengths. Two codes are reserved and raise an error flag. When the left and right slots of one frame have both been captured, the block presents both words and pulses a one-cycle valid strobe.

Top module: `aud_serial_rx`

## Requirements
- R1: Mode 3'b000 is left-justified. The MSB is the bit sampled on the first bit-clock rise after the frame clock changes. A low frame clock marks the left slot.
- R2: Mode 3'b001 is the delayed format. The MSB is the bit one bit clock after the frame clock edge. A high frame clock marks the left slot, and the first bit of each slot still belongs to the previous slot.
- R3: Modes 3'b010 and 3'b011 are reserved. One cycle after such a mode is applied, mode_err_o is high, and valid_o stays low for as long as the mode stays reserved.
- R4: Modes 3'b100, 3'b101, 3'b110 and 3'b111 are right-justified. Each word is taken from the last 16, 18, 20 or 24 bits of its slot, and earlier filler bits are ignored.
- R5: Right-justified slots are 32 bit clocks long, so a frame is 64 bit clocks.
- R6: In modes 3'b000 and 3'b001, packed frames with 16-bit slots (32 bit clocks per frame) are accepted.
- R7: Words arrive MSB first and are left-aligned into the 24-bit output with zeros below the received bits. Bits beyond the 24th bit of a slot are dropped.
- R8: valid_o pulses for exactly one cycle. The pulse comes the cycle after the bit-clock rise that ends a right slot, and only if the left slot of the same frame was captured. The first slot after reset, or after leaving a reserved mode, is discarded.
- R9: left_o and right_o change only together with a valid_o pulse and hold their value otherwise.
- R10: While rst_ni is low, left_o and right_o are zero and valid_o and mode_err_o are low.
- R11: Inputs are sampled on rising bit-clock edges, seen as a low-to-high change of bclk_i between two system clocks. Each bit-clock phase must last at least one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock, sampled by clk_i |
| lrclk_i | input | 1 | Frame (channel select) clock |
| sdata_i | input | 1 | Serial data, MSB first |
| mode_i | input | 3 | Static framing mode code |
| left_o | output | 24 | Left-channel sample, left-aligned |
| right_o | output | 24 | Right-channel sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe: new frame available |
| mode_err_o | output | 1 | Reserved mode selected |

## Verification
Four properties are checked on every cycle:
- the error flag follows a reserved mode;
- no strobe coincides with the flag;
- the strobe never lasts two cycles;
- the sample words hold steady between strobes, and right-justified 16-bit words carry zero low bytes.

Whether the bits land in the right place can only be shown by scenarios, because it depends on slot length, frame-clock polarity, the one-bit delay and word length. The bench checks this by sending known words in every mode. It uses full 32-clock slots with filler bits and packed 16-clock slots, and compares against a behavioural model of the bit stream.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int unsigned WORD_W = 24;
  localparam int unsigned SLOT_W = 32;

  typedef enum logic [2:0] {
    MODE_LJ    = 3'b000,
    MODE_DLY   = 3'b001,
    MODE_RSV0  = 3'b010,
    MODE_RSV1  = 3'b011,
    MODE_RJ16  = 3'b100,
    MODE_RJ18  = 3'b101,
    MODE_RJ20  = 3'b110,
    MODE_RJ24  = 3'b111
  } rx_mode_e;

  function automatic logic mode_is_rsv(logic [2:0] m);
    return m[2:1] == 2'b01;
  endfunction

  function automatic logic mode_is_rj(logic [2:0] m);
    return m[2];
  endfunction

  function automatic int unsigned rj_len(logic [2:0] m);
    case (m[1:0])
      2'b00:   return 16;
      2'b01:   return 18;
      2'b10:   return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/aud_rx_ws_track.sv
// Bit-clock rise detect and effective channel select (low = left slot).
module aud_rx_ws_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bclk_i,
  input  logic       lrclk_i,
  input  logic       dly_mode_i,
  output logic       rise_o,
  output logic       ws_o,
  output logic       ws_prev_o,
  output logic       bound_o
);
  logic bclk_q, lr_bit_q, ws_q;

  assign rise_o    = bclk_i & ~bclk_q;
  // delayed format: frame clock lags one bit and is inverted
  assign ws_o      = dly_mode_i ? ~lr_bit_q : lrclk_i;
  assign ws_prev_o = ws_q;
  assign bound_o   = rise_o & (ws_o != ws_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q   <= 1'b0;
      lr_bit_q <= 1'b0;
      ws_q     <= 1'b0;
    end else begin
      bclk_q <= bclk_i;
      if (rise_o) begin
        lr_bit_q <= lrclk_i;
        ws_q     <= ws_o;
      end
    end
  end
endmodule

// File: rtl/aud_rx_slot_cap.sv
// Collects one slot; word_o is the finished word of the slot in progress.
module aud_rx_slot_cap #(
  parameter int unsigned WORD_W = aud_rx_pkg::WORD_W,
  parameter int unsigned SLOT_W = aud_rx_pkg::SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              start_i,
  input  logic              din_i,
  input  logic [2:0]        mode_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] acc_q;
  logic [SLOT_W-1:0] sh_q;
  logic [CW-1:0]     cnt_q;
  logic [SLOT_W-1:0] rj_mask, rj_full;
  int unsigned       rj_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (bit_en_i) begin
      if (start_i) begin
        acc_q <= {din_i, {(WORD_W-1){1'b0}}};
        sh_q  <= {{(SLOT_W-1){1'b0}}, din_i};
        cnt_q <= CW'(1);
      end else begin
        if (cnt_q < CW'(WORD_W)) begin
          acc_q[WORD_W-1-int'(cnt_q)] <= din_i;
          cnt_q <= cnt_q + CW'(1);
        end
        sh_q <= {sh_q[SLOT_W-2:0], din_i};
      end
    end
  end

  always_comb begin
    rj_n    = aud_rx_pkg::rj_len(mode_i);
    rj_mask = (SLOT_W'(1) << rj_n) - SLOT_W'(1);
    rj_full = (sh_q & rj_mask) << (WORD_W - rj_n);
    word_o  = aud_rx_pkg::mode_is_rj(mode_i) ? rj_full[WORD_W-1:0] : acc_q;
  end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
  parameter int unsigned WORD_W = aud_rx_pkg::WORD_W,
  parameter int unsigned SLOT_W = aud_rx_pkg::SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              sdata_i,
  input  logic [2:0]        mode_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              mode_err_o
);
  import aud_rx_pkg::*;

  logic              rise, ws, ws_prev, bound, rsv;
  logic [WORD_W-1:0] word, left_hold_q;
  logic              synced_q, have_left_q;

  assign rsv = mode_is_rsv(mode_i);

  aud_rx_ws_track u_ws (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_i     (bclk_i),
    .lrclk_i    (lrclk_i),
    .dly_mode_i (mode_i == MODE_DLY),
    .rise_o     (rise),
    .ws_o       (ws),
    .ws_prev_o  (ws_prev),
    .bound_o    (bound)
  );

  aud_rx_slot_cap #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (rise),
    .start_i  (bound),
    .din_i    (sdata_i),
    .mode_i   (mode_i),
    .word_o   (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o      <= '0;
      right_o     <= '0;
      left_hold_q <= '0;
      valid_o     <= 1'b0;
      mode_err_o  <= 1'b0;
      synced_q    <= 1'b0;
      have_left_q <= 1'b0;
    end else begin
      valid_o    <= 1'b0;
      mode_err_o <= rsv;
      if (rsv) begin
        synced_q    <= 1'b0;
        have_left_q <= 1'b0;
      end else if (bound) begin
        synced_q <= 1'b1;
        if (synced_q) begin
          if (!ws_prev) begin
            left_hold_q <= word;
            have_left_q <= 1'b1;
          end else if (have_left_q) begin
            left_o      <= left_hold_q;
            right_o     <= word;
            valid_o     <= 1'b1;
            have_left_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int unsigned WORD_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        mode_i,
  input logic [WORD_W-1:0] left_o,
  input logic [WORD_W-1:0] right_o,
  input logic              valid_o,
  input logic              mode_err_o
);
  a_r3_err_follows_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2:1] == 2'b01) |=> mode_err_o);

  a_r3_no_valid_in_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> !valid_o);

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r9_hold_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  a_r7_rj16_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == 3'b100) |-> (left_o[7:0] == 8'h0 && right_o[7:0] == 8'h0));
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .left_o     (left_o),
  .right_o    (right_o),
  .valid_o    (valid_o),
  .mode_err_o (mode_err_o)
);

// File: tb/aud_serial_rx_tb.sv
module aud_serial_rx_tb;
  localparam int CLK_P = 10;
  localparam int WDOG  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [23:0] left_w, right_w;
  logic        valid_w, err_w;

  int n_chk = 0, n_fail = 0, cyc = 0, vcnt = 0;
  logic [23:0] last_l = '0, last_r = '0;
  logic        d_prev = 1'b0;

  aud_serial_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .lrclk_i(lrclk),
    .sdata_i(sdata), .mode_i(mode), .left_o(left_w), .right_o(right_w),
    .valid_o(valid_w), .mode_err_o(err_w)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  bit          mq[$];
  logic        m_bq, m_lrb, m_ws, m_sync, m_hl, m_v, m_err;
  logic [23:0] m_lh, m_l, m_r;

  function automatic logic is_rsv(logic [2:0] m);
    return (m == 3'b010) || (m == 3'b011);
  endfunction

  function automatic int wlen(logic [2:0] m);
    case (m)
      3'b100: return 16;
      3'b101: return 18;
      3'b110: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] mk_word(logic [2:0] m);
    logic [23:0] w = '0;
    int sz = mq.size();
    if (m[2]) begin
      int n = wlen(m);
      for (int i = 0; i < n; i++)
        if (sz - n + i >= 0) w[23-i] = mq[sz-n+i];
    end else begin
      for (int k = 0; k < sz && k < 24; k++) w[23-k] = mq[k];
    end
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bq = 0; m_lrb = 0; m_ws = 0; m_sync = 0; m_hl = 0; m_v = 0; m_err = 0;
      m_lh = '0; m_l = '0; m_r = '0; mq.delete();
    end else begin
      logic ws;
      logic rise;
      m_v   = 0;
      m_err = is_rsv(mode);
      rise  = bclk && !m_bq;
      m_bq  = bclk;
      if (is_rsv(mode)) begin m_sync = 0; m_hl = 0; end
      if (rise) begin
        ws = (mode == 3'b001) ? !m_lrb : lrclk;
        m_lrb = lrclk;
        if (ws != m_ws) begin
          if (m_sync && !is_rsv(mode)) begin
            if (!m_ws) begin m_lh = mk_word(mode); m_hl = 1; end
            else if (m_hl) begin m_l = m_lh; m_r = mk_word(mode); m_v = 1; m_hl = 0; end
          end
          if (!is_rsv(mode)) m_sync = 1;
          mq.delete();
        end
        mq.push_back(sdata);
        m_ws = ws;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WDOG);
      finish_run();
    end
  end

  // per-cycle comparison (R8 strobe, R9 hold, R3 flag, R11 sampling)
  task automatic tick();
    @(negedge clk);
    chk(valid_w == m_v, "R8 valid", 48'(valid_w), 48'(m_v));
    chk(err_w == m_err, "R3 mode_err", 48'(err_w), 48'(m_err));
    chk(left_w == m_l && right_w == m_r, "R9/R11 words", {left_w, right_w}, {m_l, m_r});
    if (valid_w) begin vcnt++; last_l = left_w; last_r = right_w; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bclk = 0; lrclk = 0; sdata = 0;
    tick(); tick();
    chk(left_w == 0 && right_w == 0 && !valid_w && !err_w, "R10 reset state",
        {left_w, right_w}, 48'h0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic send_bit(input logic lr, input logic d);
    bclk = 0; lrclk = lr; sdata = d;
    tick(); tick();
    bclk = 1;
    tick(); tick();
  endtask

  task automatic emit(input logic ws, input logic d);
    if (mode == 3'b001) begin send_bit(~ws, d_prev); d_prev = d; end
    else send_bit(ws, d);
  endtask

  function automatic int nbits(logic [2:0] m, int slot);
    if (m[2]) return wlen(m);
    return (slot < 24) ? slot : 24;
  endfunction

  // filler bits are ones so dropped/ignored bits are visible
  function automatic logic dbit(logic [2:0] m, logic [23:0] w, int k, int slot);
    int n = nbits(m, slot);
    if (m[2]) return (k >= slot - n) ? w[23-(k-(slot-n))] : 1'b1;
    return (k < n) ? w[23-k] : 1'b1;
  endfunction

  function automatic logic [23:0] word_of(int f, bit ch);
    return ch ? (24'h3C96A5 ^ (24'h05A1F3 * (f + 1))) : (24'hC3E15B + 24'h111111 * f);
  endfunction

  task automatic run_mode(input logic [2:0] m, input int slot, input string req);
    logic [23:0] mask, el, er;
    int n;
    mode = m; d_prev = 0;
    do_reset();
    vcnt = 0;
    for (int f = 0; f < 4; f++)
      for (int ch = 0; ch < 2; ch++)
        for (int k = 0; k < slot; k++)
          emit(ch[0], dbit(m, word_of(f, ch[0]), k, slot));
    n = nbits(m, slot);
    mask = ~(24'hFFFFFF >> n);
    if (is_rsv(m)) begin
      chk(vcnt == 0, {req, " no samples"}, 48'(vcnt), 48'h0);
      chk(err_w == 1'b1, {req, " flag"}, 48'(err_w), 48'h1);
    end else begin
      el = word_of(2, 1'b0) & mask;
      er = word_of(2, 1'b1) & mask;
      chk(vcnt >= 1, {req, " strobe seen"}, 48'(vcnt), 48'h1);
      chk(last_l == el, {req, " left word"}, 48'(last_l), 48'(el));
      chk(last_r == er, {req, " right word"}, 48'(last_r), 48'(er));
    end
  endtask

  initial begin
    run_mode(3'b000, 32, "R1/R7 LJ 32-clock slot");
    run_mode(3'b000, 16, "R6 LJ packed");
    run_mode(3'b001, 32, "R2/R7 delayed 32-clock slot");
    run_mode(3'b001, 16, "R6 delayed packed");
    run_mode(3'b100, 32, "R4/R5 RJ16");
    run_mode(3'b101, 32, "R4/R5 RJ18");
    run_mode(3'b110, 32, "R4/R5 RJ20");
    run_mode(3'b111, 32, "R4/R5 RJ24");
    run_mode(3'b010, 32, "R3 reserved 010");
    run_mode(3'b011, 32, "R3 reserved 011");
    // leaving a reserved mode without reset: resync then capture (R8)
    mode = 3'b000; vcnt = 0;
    for (int f = 0; f < 4; f++)
      for (int ch = 0; ch < 2; ch++)
        for (int k = 0; k < 32; k++)
          emit(ch[0], dbit(3'b000, word_of(f, ch[0]), k, 32));
    chk(err_w == 1'b0, "R3 flag clears", 48'(err_w), 48'h0);
    chk(vcnt >= 1 && last_l == word_of(2, 1'b0), "R8 resync after reserved",
        48'(last_l), 48'(word_of(2, 1'b0)));
    finish_run();
  end
endmodule